// File: doc/BRIEF.md
# Packed Halfword-to-Float Converter

This block turns two signed integers, carried in a 64-bit packed operand, into two IEEE-754 single-precision values in one clock. The operand holds two 32-bit lanes. In the default halfword mode, each lane contributes only its low 16 bits as a two's-complement integer. The result for each lane goes back into the same 32-bit slot it came from. Each 16-bit value fits inside the 24-bit significand, so the halfword conversion is always exact.

An 8-bit operation code arrives with the data and selects the mode. Code 0Dh selects word mode, which converts the full 32-bit lane and rounds to nearest, with ties going to even. Any other code, including the halfword code 0Ch, selects halfword mode. An operand is accepted when `inVal` is high. The converted value and `outVal` appear on the next rising clock edge.

Top module: `i2f_packed_cvt`

## Requirements
- R1: In halfword mode, lane 0 converts the signed value in source bits 15..0 into result bits 31..0. Lane 1 converts source bits 47..32 into result bits 63..32. Each result has the sign in bit 31, an 8-bit biased exponent (bias 127) in bits 30..23, and a 23-bit fraction in bits 22..0.
- R2: In halfword mode, source bits 31..16 and 63..48 have no effect on the result.
- R3: A zero source value in a lane produces a lane result of all zeros (+0.0).
- R4: The source value -32768 (8000h) produces C7000000h, which is sign 1, exponent 142 and fraction 0.
- R5: Every halfword conversion is exact, so the result equals the source value with no rounding. For this reason the biased exponent never exceeds 142.
- R6: Operation code 0Dh selects word mode. Word mode converts each full 32-bit signed lane and rounds to nearest, with ties going to the even fraction.
- R7: Any operation code other than 0Dh, including 0Ch, selects halfword mode.
- R8: When `inVal` is high at a rising edge, `result` and `outVal`=1 appear after that same edge. When `inVal` is low at a rising edge, `outVal` is 0 after that edge.
- R9: While `inVal` is low, `result` keeps its last value.
- R10: While `rstN` is low, `result` is 0 and `outVal` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inVal | input | 1 | Operand and code are valid this cycle |
| opCode | input | 8 | Operation code: 0Dh selects word mode, any other value selects halfword mode |
| srcWord | input | 64 | Packed source operand, two 32-bit lanes |
| result | output | 64 | Packed single-precision results, registered |
| outVal | output | 1 | High for one cycle for each accepted operand |

## Verification
The datapath is combinational and feeds a single register. A wrong leading-one position, shift amount or exponent offset therefore appears at the `result` port one edge after the operand is accepted. There is no hidden state that could delay the error.

The valuable stimuli are the extremes and the rounding boundaries. Zero, ±1, 32767 and -32768 exercise the exponent and the sign handling. Word-mode values just above 2^24 exercise the guard and sticky bits and carries into the exponent. Garbage in the ignored upper halves shows whether the lane select leaks into the result. A control fault, such as a missing load enable or a stuck valid flag, shows up on the edge right after `inVal` changes.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadEn;   // capture converted lanes this edge
    logic wideSrc;  // convert full lane with rounding
  } cvtCtrl_t;

  localparam logic [7:0] CODE_WIDE = 8'h0D;
  localparam int FRAC_W = 23;
  localparam int EXP_W = 8;
  localparam int EXP_BIAS = 127;
endpackage

// File: rtl/i2f_ctrl.sv
module i2f_ctrl
  import i2f_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inVal,
  input  logic [7:0] opCode,
  output cvtCtrl_t   ctrl,
  output logic       outVal
);
  always_comb begin
    ctrl.loadEn  = inVal;
    ctrl.wideSrc = (opCode == CODE_WIDE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outVal <= 1'b0;
    else       outVal <= inVal;
  end
endmodule

// File: rtl/i2f_lane.sv
module i2f_lane
  import i2f_pkg::*;
#(
  parameter int LANE_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic [LANE_W-1:0] laneIn,
  input  logic              wideSrc,
  output logic [31:0]       fpOut
);
  localparam int PW = $clog2(LANE_W);
  localparam int GUARD_POS = LANE_W - 2 - FRAC_W;

  logic [LANE_W-1:0] srcVal;
  logic [LANE_W-1:0] mag;
  logic [LANE_W-1:0] norm;
  logic [PW-1:0]     leadPos;
  logic [PW-1:0]     shiftAmt;
  logic              sgn;
  logic [FRAC_W-1:0] frac;
  logic [EXP_W-1:0]  expo;
  logic              guardBit;
  logic              stickyBit;
  logic              rndUp;
  logic [EXP_W+FRAC_W-1:0] body;

  // sign extension / lane select
  always_comb begin
    if (wideSrc) srcVal = laneIn;
    else srcVal = {{(LANE_W-NARROW_W){laneIn[NARROW_W-1]}}, laneIn[NARROW_W-1:0]};
    sgn = srcVal[LANE_W-1];
    mag = sgn ? (~srcVal + 1'b1) : srcVal;
  end

  // leading-one detection
  always_comb begin
    leadPos = '0;
    for (int i = 0; i < LANE_W; i++) begin
      if (mag[i]) leadPos = PW'(i);
    end
  end

  // normalize, round, pack
  always_comb begin
    shiftAmt  = PW'(LANE_W - 1) - leadPos;
    norm      = mag << shiftAmt;
    frac      = norm[LANE_W-2 -: FRAC_W];
    guardBit  = norm[GUARD_POS];
    stickyBit = |norm[GUARD_POS-1:0];
    expo      = EXP_W'(EXP_BIAS) + EXP_W'(leadPos);
    rndUp     = wideSrc & guardBit & (stickyBit | frac[0]);
    body      = {expo, frac} + (EXP_W+FRAC_W)'(rndUp);
    fpOut     = norm[LANE_W-1] ? {sgn, body} : 32'h0;
  end
endmodule

// File: rtl/i2f_datapath.sv
module i2f_datapath
  import i2f_pkg::*;
#(
  parameter int LANES    = 2,
  parameter int LANE_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  cvtCtrl_t                ctrl,
  input  logic [LANES*LANE_W-1:0] srcWord,
  output logic [LANES*32-1:0]     result
);
  logic [LANES*32-1:0] convNext;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    i2f_lane #(.LANE_W(LANE_W), .NARROW_W(NARROW_W)) uLane (
      .laneIn (srcWord[g*LANE_W +: LANE_W]),
      .wideSrc(ctrl.wideSrc),
      .fpOut  (convNext[g*32 +: 32])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            result <= '0;
    else if (ctrl.loadEn) result <= convNext;
  end
endmodule

// File: rtl/i2f_packed_cvt.sv
module i2f_packed_cvt
  import i2f_pkg::*;
#(
  parameter int LANES    = 2,
  parameter int LANE_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inVal,
  input  logic [7:0]              opCode,
  input  logic [LANES*LANE_W-1:0] srcWord,
  output logic [LANES*32-1:0]     result,
  output logic                    outVal
);
  cvtCtrl_t ctrl;

  i2f_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inVal(inVal), .opCode(opCode),
    .ctrl(ctrl), .outVal(outVal)
  );

  i2f_datapath #(.LANES(LANES), .LANE_W(LANE_W), .NARROW_W(NARROW_W)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .srcWord(srcWord), .result(result)
  );
endmodule

// File: rtl/i2f_packed_cvt_chk.sv
module i2f_packed_cvt_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inVal,
  input logic [7:0]  opCode,
  input logic [63:0] srcWord,
  input logic [63:0] result,
  input logic        outVal
);
  logic narrowOp;
  assign narrowOp = inVal && (opCode != 8'h0D);

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inVal |=> outVal);
  // R8
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inVal |=> !outVal);
  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inVal |=> $stable(result));
  // R1
  lane_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    narrowOp |=> (result[31] == $past(srcWord[15])) && (result[63] == $past(srcWord[47])));
  // R3
  zero_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (narrowOp && srcWord[15:0] == 16'h0) |=> (result[31:0] == 32'h0));
  // R4
  min_neg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (narrowOp && srcWord[47:32] == 16'h8000) |=> (result[63:32] == 32'hC700_0000));
  // R5
  exp_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    narrowOp |=> (result[30:23] <= 8'd142) && (result[62:55] <= 8'd142));
  // R10
  always_comb begin
    if (!rstN) begin
      reset_state_chk: assert (result == 64'h0 && !outVal);
    end
  end
endmodule

bind i2f_packed_cvt i2f_packed_cvt_chk uChk (
  .clk(clk), .rstN(rstN), .inVal(inVal), .opCode(opCode),
  .srcWord(srcWord), .result(result), .outVal(outVal)
);

// File: tb/tb_i2f_packed_cvt.sv
module tb_i2f_packed_cvt;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inVal = 1'b0;
  logic [7:0]  opCode = 8'h0C;
  logic [63:0] srcWord = '0;
  logic [63:0] result;
  logic        outVal;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  i2f_packed_cvt dut (
    .clk(clk), .rstN(rstN), .inVal(inVal), .opCode(opCode),
    .srcWord(srcWord), .result(result), .outVal(outVal)
  );

  // Reference: integer -> double (exact) -> single with round-to-nearest-even
  function automatic logic [31:0] refF(input longint v);
    logic [63:0] d;
    logic [7:0]  e;
    logic [22:0] m;
    logic        up;
    real r;
    if (v == 0) return 32'h0;
    r = v;
    d = $realtobits(r);
    e = 8'(d[62:52] - 11'd896);
    m = d[51:29];
    up = d[28] & ((|d[27:0]) | m[0]);
    return {d[63], {e, m} + 31'(up)};
  endfunction

  function automatic logic [31:0] refNarrow(input logic [15:0] h);
    return refF(longint'($signed(h)));
  endfunction

  function automatic logic [31:0] refWide(input logic [31:0] w);
    return refF(longint'($signed(w)));
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // apply one operand, sample just after the capturing edge
  task automatic apply(input logic [7:0] code, input logic [63:0] src);
    @(negedge clk);
    inVal = 1'b1; opCode = code; srcWord = src;
    @(posedge clk); #1;
    chk("R8 outVal", {63'h0, outVal}, 64'h1);
    @(negedge clk);
    inVal = 1'b0;
  endtask

  task automatic tReset();
    #1;
    chk("R10 reset result", result, 64'h0);
    chk("R10 reset outVal", {63'h0, outVal}, 64'h0);
    repeat (2) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic tNarrowBasic();
    logic [15:0] a [5] = '{16'd1, 16'hFFFF, 16'd32767, 16'd300, 16'hFF85};
    logic [15:0] b [5] = '{16'd2, 16'd100, 16'hC000, 16'hFFFE, 16'd12345};
    for (int i = 0; i < 5; i++) begin
      apply(8'h0C, {16'h0, b[i], 16'h0, a[i]});
      chk("R1 lanes", result, {refNarrow(b[i]), refNarrow(a[i])});
      chk("R5 exact", {32'h0, result[31:0]}, {32'h0, refNarrow(a[i])});
    end
    apply(8'h0C, {16'h0, 16'd1, 16'h0, 16'd1});
    chk("R1 one", result, 64'h3F80_0000_3F80_0000);
  endtask

  task automatic tIgnoreUpper();
    apply(8'h0C, {16'hDEAD, 16'd7, 16'hBEEF, 16'hFFF9});
    chk("R2 upper ignored", result, {refNarrow(16'd7), refNarrow(16'hFFF9)});
    apply(8'h0C, {16'hFFFF, 16'h0, 16'h7FFF, 16'h0});
    chk("R2 upper ignored zero", result, 64'h0);
  endtask

  task automatic tZeroMin();
    apply(8'h0C, {16'h1234, 16'h8000, 16'h5678, 16'h0000});
    chk("R3 zero lane", {32'h0, result[31:0]}, 64'h0);
    chk("R4 min lane", {32'h0, result[63:32]}, 64'hC700_0000);
  endtask

  task automatic tWide();
    logic [31:0] w [6] = '{32'h0100_0001, 32'h0100_0003, 32'h8000_0000,
                           32'h7FFF_FFFF, 32'hFEFF_FFFF, 32'h0001_0000};
    for (int i = 0; i < 6; i += 2) begin
      apply(8'h0D, {w[i+1], w[i]});
      chk("R6 wide rne", result, {refWide(w[i+1]), refWide(w[i])});
    end
    apply(8'h0D, {32'h0100_0003, 32'h0100_0001});
    chk("R6 tie cases", result, 64'h4B80_0002_4B80_0000);
  endtask

  task automatic tOtherCode();
    apply(8'hBB, {32'h0001_0005, 32'h7FFF_0003});
    chk("R7 other code narrow", result, {refNarrow(16'd5), refNarrow(16'd3)});
  endtask

  task automatic tHold();
    apply(8'h0C, {16'h0, 16'd9, 16'h0, 16'd10});
    @(negedge clk);
    srcWord = 64'h0000_1111_0000_2222; opCode = 8'h0D;
    @(posedge clk); #1;
    chk("R8 outVal low", {63'h0, outVal}, 64'h0);
    chk("R9 hold", result, {refNarrow(16'd9), refNarrow(16'd10)});
    repeat (3) @(posedge clk); #1;
    chk("R9 hold later", result, {refNarrow(16'd9), refNarrow(16'd10)});
  endtask

  task automatic tBackToBack();
    @(negedge clk);
    inVal = 1'b1; opCode = 8'h0C; srcWord = {16'h0, 16'd4, 16'h0, 16'd8};
    @(posedge clk); #1;
    chk("R8 b2b first", result, {refNarrow(16'd4), refNarrow(16'd8)});
    @(negedge clk);
    srcWord = {16'h0, 16'hFFF0, 16'h0, 16'd64};
    @(posedge clk); #1;
    chk("R8 b2b second", result, {refNarrow(16'hFFF0), refNarrow(16'd64)});
    chk("R8 b2b valid", {63'h0, outVal}, 64'h1);
    @(negedge clk); inVal = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tReset();
    tNarrowBasic();
    tIgnoreUpper();
    tZeroMin();
    tWide();
    tOtherCode();
    tHold();
    tBackToBack();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule